// File: doc/BRIEF.md
# Transport Receive Packet Router

The router sits between a link layer and a set of logical-layer engines on the receive side of a serial packet interconnect. Packets arrive as a beat stream with start and end markers, together with header fields extracted by the link layer and a flag marking link-level corruption. On the first beat the router inspects the transport type, destination ID, format type and target transaction ID. It then steers the whole packet to one logical-layer port, to a generic pass-through port, or into a discard path.

Request packets are sent to the engine whose format-type mask includes their type. Response packets are sent to the engine that owns their transaction ID. Traffic that no engine claims goes to pass-through. Packets that cannot be delivered raise a one-cycle drop pulse, but link-corrupted packets vanish without one. The routing datapath is combinational. The only state is a register that holds the decision for the remaining beats of the packet. A stalled destination therefore back-pressures the link directly, and packets leave in arrival order.

Top module: `rx_pkt_router`

## Requirements
- R1: A packet whose `in_err` is high on its start beat is accepted and discarded on every beat: no output valid rises and `drop_pulse` stays low.
- R2: Transport type 0 means an 8-bit device ID and type 1 means a 16-bit device ID. With `DEVID16_EN`=1, a tt=0 packet goes to pass-through.
- R3: With `DEVID16_EN`=0, a tt=1 packet is always discarded with a drop pulse, even when pass-through exists.
- R4: With `DESTID_CHECK`=1, a tt-matched packet is discarded with a drop pulse if its destination does not equal `MY_ID`. The full 16 bits are compared in 16-bit mode and the low 8 bits in 8-bit mode.
- R5: A tt-matched packet with ftype other than 13 goes to the lowest-indexed port whose `FTYPE_MASK` slice (16 bits per port, bit n = ftype n) has that ftype's bit set.
- R6: A tt-matched packet whose ftype (other than 13) is in no port's mask goes to pass-through.
- R7: A tt-matched packet with ftype 13 goes to the lowest-indexed port p with `TID_LO[p]` <= tid <= `TID_HI[p]`. A tid in no range goes to pass-through, and mask bits play no part.
- R8: With `PASSTHRU_EN`=0, every packet that would have gone to pass-through is discarded with a drop pulse, and `pt_valid` never rises.
- R9: The decision is taken from the header fields on the start beat only. Every beat of the packet reaches the same output with its data and markers unchanged.
- R10: At most one output valid is high. It mirrors `in_valid`, and `in_ready` equals the ready of the chosen output. A discarded packet is always ready.
- R11: `drop_pulse` is high only in the cycle that accepts the end beat of a packet discarded under R3, R4 or R8.
- R12: Transport types 2 and 3 never match. Such packets go to pass-through when it exists, otherwise they are discarded with a drop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound beat valid |
| in_ready | output | 1 | Inbound beat accepted |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_data | input | DATA_W | Beat payload |
| in_err | input | 1 | Link-errored packet (start beat) |
| in_tt | input | 2 | Transport type (start beat) |
| in_ftype | input | 4 | Format type (start beat) |
| in_dest | input | 16 | Destination ID (start beat) |
| in_tid | input | TID_W | Target transaction ID (start beat) |
| lp_valid | output | NUM_PORTS | Per-port beat valid |
| lp_ready | input | NUM_PORTS | Per-port ready |
| lp_sop | output | NUM_PORTS | Per-port first-beat marker |
| lp_eop | output | NUM_PORTS | Per-port last-beat marker |
| lp_data | output | NUM_PORTS*DATA_W | Per-port payload, port p at slice p |
| pt_valid | output | 1 | Pass-through beat valid |
| pt_ready | input | 1 | Pass-through ready |
| pt_sop | output | 1 | Pass-through first-beat marker |
| pt_eop | output | 1 | Pass-through last-beat marker |
| pt_data | output | DATA_W | Pass-through payload |
| drop_pulse | output | 1 | Undeliverable packet discarded |

## Verification
The bench builds two instances with three ports, format-type masks that overlap on ftype 5, and transaction-ID ranges that overlap from 48 to 63. The first instance uses 16-bit IDs, destination checking and a pass-through port. It exercises tt=0 diversion, destination mismatch drops, range edges at 31/32, 63/64 and 95/96, and lowest-port priority. The second instance uses 8-bit IDs, no destination check and no pass-through port. It makes the tt=1 drop and the missing pass-through drop reachable, and shows that foreign destinations are accepted when checking is off.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    // Disposition of a packet chosen on its start beat
    typedef enum logic [1:0] {
        RK_PORT       = 2'd0,
        RK_PASS       = 2'd1,
        RK_DROP_LOUD  = 2'd2,
        RK_DROP_QUIET = 2'd3
    } rkind_e;

    localparam logic [1:0] TT_NARROW = 2'd0;
    localparam logic [1:0] TT_WIDE   = 2'd1;
    localparam logic [3:0] FT_RESP   = 4'd13;
endpackage

// File: rtl/rxr_classify.sv
module rxr_classify
    import rxr_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int TID_W = 8,
    parameter bit DEVID16_EN = 1'b1,
    parameter bit DESTID_CHECK = 1'b1,
    parameter bit PASSTHRU_EN = 1'b1,
    parameter logic [15:0] MY_ID = 16'h1234,
    parameter logic [NUM_PORTS*16-1:0] FTYPE_MASK = 48'h0500_0060_0024,
    parameter logic [NUM_PORTS*TID_W-1:0] TID_LO = 24'h30_20_00,
    parameter logic [NUM_PORTS*TID_W-1:0] TID_HI = 24'h5F_3F_1F,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic             hdr_err,
    input  logic [1:0]       hdr_tt,
    input  logic [3:0]       hdr_ftype,
    input  logic [15:0]      hdr_dest,
    input  logic [TID_W-1:0] hdr_tid,
    output rkind_e           hdr_kind,
    output logic [PW-1:0]    hdr_port
);
    localparam logic [1:0] TT_OWN = DEVID16_EN ? TT_WIDE : TT_NARROW;
    localparam rkind_e MISS_KIND = PASSTHRU_EN ? RK_PASS : RK_DROP_LOUD;

    function automatic logic in_span(input logic [TID_W-1:0] v,
                                     input logic [TID_W-1:0] lo,
                                     input logic [TID_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    logic [NUM_PORTS-1:0] ft_hit;
    logic [NUM_PORTS-1:0] tid_hit;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam logic [15:0]      P_MASK = FTYPE_MASK[g*16 +: 16];
        localparam logic [TID_W-1:0] P_LO   = TID_LO[g*TID_W +: TID_W];
        localparam logic [TID_W-1:0] P_HI   = TID_HI[g*TID_W +: TID_W];
        assign ft_hit[g]  = P_MASK[hdr_ftype];
        assign tid_hit[g] = in_span(hdr_tid, P_LO, P_HI);
    end

    logic          ft_any, tid_any, dest_ok;
    logic [PW-1:0] ft_sel, tid_sel;

    // Lowest index wins: scan downward so the last hit written is the lowest
    always_comb begin
        ft_any  = 1'b0;
        tid_any = 1'b0;
        ft_sel  = '0;
        tid_sel = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (ft_hit[i]) begin
                ft_any = 1'b1;
                ft_sel = PW'(i);
            end
            if (tid_hit[i]) begin
                tid_any = 1'b1;
                tid_sel = PW'(i);
            end
        end
    end

    assign dest_ok = DEVID16_EN ? (hdr_dest == MY_ID)
                                : (hdr_dest[7:0] == MY_ID[7:0]);

    always_comb begin
        hdr_kind = RK_DROP_QUIET;
        hdr_port = '0;
        if (hdr_err) begin
            hdr_kind = RK_DROP_QUIET;
        end else if (hdr_tt != TT_OWN) begin
            if (!DEVID16_EN && hdr_tt == TT_WIDE) hdr_kind = RK_DROP_LOUD;
            else                                 hdr_kind = MISS_KIND;
        end else if (DESTID_CHECK && !dest_ok) begin
            hdr_kind = RK_DROP_LOUD;
        end else if (hdr_ftype == FT_RESP) begin
            hdr_kind = tid_any ? RK_PORT : MISS_KIND;
            hdr_port = tid_sel;
        end else begin
            hdr_kind = ft_any ? RK_PORT : MISS_KIND;
            hdr_port = ft_sel;
        end
    end
endmodule

// File: rtl/rxr_route_hold.sv
module rxr_route_hold
    import rxr_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_acc,
    input  logic          beat_sop,
    input  logic          beat_eop,
    input  rkind_e        hdr_kind,
    input  logic [PW-1:0] hdr_port,
    output rkind_e        cur_kind,
    output logic [PW-1:0] cur_port
);
    typedef struct packed {
        logic          busy;
        rkind_e        kind;
        logic [PW-1:0] port;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (beat_acc && beat_sop) begin
            st_d.busy = !beat_eop;
            st_d.kind = hdr_kind;
            st_d.port = hdr_port;
        end else if (beat_acc && beat_eop) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, kind: RK_DROP_QUIET, port: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // Start beat uses the fresh decision; stray continuation beats are shed
    always_comb begin
        if (beat_sop) begin
            cur_kind = hdr_kind;
            cur_port = hdr_port;
        end else if (st_q.busy) begin
            cur_kind = st_q.kind;
            cur_port = st_q.port;
        end else begin
            cur_kind = RK_DROP_QUIET;
            cur_port = '0;
        end
    end
endmodule

// File: rtl/rxr_out_demux.sv
module rxr_out_demux
    import rxr_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int DATA_W = 32,
    parameter bit PASSTHRU_EN = 1'b1,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  rkind_e                      cur_kind,
    input  logic [PW-1:0]               cur_port,
    input  logic                        in_valid,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic [DATA_W-1:0]           in_data,
    output logic                        in_ready,
    output logic [NUM_PORTS-1:0]        lp_valid,
    input  logic [NUM_PORTS-1:0]        lp_ready,
    output logic [NUM_PORTS-1:0]        lp_sop,
    output logic [NUM_PORTS-1:0]        lp_eop,
    output logic [NUM_PORTS*DATA_W-1:0] lp_data,
    output logic                        pt_valid,
    input  logic                        pt_ready,
    output logic                        pt_sop,
    output logic                        pt_eop,
    output logic [DATA_W-1:0]           pt_data,
    output logic                        drop_pulse
);
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_lane
        logic sel;
        assign sel         = (cur_kind == RK_PORT) && (cur_port == PW'(g));
        assign lp_valid[g] = in_valid && sel;
        assign lp_sop[g]   = in_sop;
        assign lp_eop[g]   = in_eop;
        assign lp_data[g*DATA_W +: DATA_W] = in_data;
    end

    assign pt_valid = PASSTHRU_EN && in_valid && (cur_kind == RK_PASS);
    assign pt_sop   = in_sop;
    assign pt_eop   = in_eop;
    assign pt_data  = in_data;

    logic port_rdy;
    always_comb begin
        port_rdy = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (cur_port == PW'(i)) port_rdy = lp_ready[i];
        end
    end

    always_comb begin
        case (cur_kind)
            RK_PORT: in_ready = port_rdy;
            RK_PASS: in_ready = pt_ready;
            default: in_ready = 1'b1;
        endcase
    end

    assign drop_pulse = in_valid && in_eop && (cur_kind == RK_DROP_LOUD);
endmodule

// File: rtl/rx_pkt_router.sv
module rx_pkt_router
    import rxr_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int DATA_W = 32,
    parameter int TID_W = 8,
    parameter bit DEVID16_EN = 1'b1,
    parameter bit DESTID_CHECK = 1'b1,
    parameter bit PASSTHRU_EN = 1'b1,
    parameter logic [15:0] MY_ID = 16'h1234,
    parameter logic [NUM_PORTS*16-1:0] FTYPE_MASK = 48'h0500_0060_0024,
    parameter logic [NUM_PORTS*TID_W-1:0] TID_LO = 24'h30_20_00,
    parameter logic [NUM_PORTS*TID_W-1:0] TID_HI = 24'h5F_3F_1F
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_err,
    input  logic [1:0]                  in_tt,
    input  logic [3:0]                  in_ftype,
    input  logic [15:0]                 in_dest,
    input  logic [TID_W-1:0]            in_tid,
    output logic [NUM_PORTS-1:0]        lp_valid,
    input  logic [NUM_PORTS-1:0]        lp_ready,
    output logic [NUM_PORTS-1:0]        lp_sop,
    output logic [NUM_PORTS-1:0]        lp_eop,
    output logic [NUM_PORTS*DATA_W-1:0] lp_data,
    output logic                        pt_valid,
    input  logic                        pt_ready,
    output logic                        pt_sop,
    output logic                        pt_eop,
    output logic [DATA_W-1:0]           pt_data,
    output logic                        drop_pulse
);
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    rkind_e        hdr_kind, cur_kind;
    logic [PW-1:0] hdr_port, cur_port;
    logic          beat_acc;

    assign beat_acc = in_valid && in_ready;

    rxr_classify #(
        .NUM_PORTS(NUM_PORTS), .TID_W(TID_W), .DEVID16_EN(DEVID16_EN),
        .DESTID_CHECK(DESTID_CHECK), .PASSTHRU_EN(PASSTHRU_EN), .MY_ID(MY_ID),
        .FTYPE_MASK(FTYPE_MASK), .TID_LO(TID_LO), .TID_HI(TID_HI)
    ) u_cls (
        .hdr_err(in_err), .hdr_tt(in_tt), .hdr_ftype(in_ftype),
        .hdr_dest(in_dest), .hdr_tid(in_tid),
        .hdr_kind(hdr_kind), .hdr_port(hdr_port)
    );

    rxr_route_hold #(.NUM_PORTS(NUM_PORTS)) u_hold (
        .clk(clk), .rst_n(rst_n), .beat_acc(beat_acc),
        .beat_sop(in_sop), .beat_eop(in_eop),
        .hdr_kind(hdr_kind), .hdr_port(hdr_port),
        .cur_kind(cur_kind), .cur_port(cur_port)
    );

    rxr_out_demux #(
        .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .PASSTHRU_EN(PASSTHRU_EN)
    ) u_dmx (
        .cur_kind(cur_kind), .cur_port(cur_port),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_ready(in_ready),
        .lp_valid(lp_valid), .lp_ready(lp_ready), .lp_sop(lp_sop),
        .lp_eop(lp_eop), .lp_data(lp_data),
        .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_sop(pt_sop),
        .pt_eop(pt_eop), .pt_data(pt_data),
        .drop_pulse(drop_pulse)
    );
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
    parameter int NUM_PORTS = 3,
    parameter bit DEVID16_EN = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 in_sop,
    input logic                 in_eop,
    input logic                 in_err,
    input logic [1:0]           in_tt,
    input logic [NUM_PORTS-1:0] lp_valid,
    input logic [NUM_PORTS-1:0] lp_ready,
    input logic                 pt_valid,
    input logic                 pt_ready,
    input logic                 drop_pulse
);
    logic [NUM_PORTS:0] outs, tgt_q;
    assign outs = {pt_valid, lp_valid};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               tgt_q <= '0;
        else if (in_valid && in_ready && in_eop)  tgt_q <= '0;
        else if (in_valid && in_ready && in_sop)  tgt_q <= outs;
    end

    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(outs));

    a_r10_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        (|outs) |-> in_valid);

    a_r10_stall_back: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(lp_valid & ~lp_ready)) || (pt_valid && !pt_ready)) |-> !in_ready);

    a_r1_silent_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_err) |-> (outs == '0 && !drop_pulse && in_ready));

    a_r11_pulse_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> (in_valid && in_eop && in_ready && outs == '0));

    a_r3_wide_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!DEVID16_EN && in_valid && in_sop && !in_err && in_tt == 2'd1) |-> (outs == '0));

    a_r9_route_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop && (|tgt_q)) |-> (outs == tgt_q));
endmodule

bind rx_pkt_router rxr_chk #(.NUM_PORTS(NUM_PORTS), .DEVID16_EN(DEVID16_EN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err), .in_tt(in_tt),
    .lp_valid(lp_valid), .lp_ready(lp_ready), .pt_valid(pt_valid),
    .pt_ready(pt_ready), .drop_pulse(drop_pulse)
);

// File: tb/sim_rx_pkt_router.sv
`timescale 1ns/1ps
module sim_rx_pkt_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic sel = 1'b0;

    logic        drv_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_tt = '0;
    logic [3:0]  in_ftype = '0;
    logic [15:0] in_dest = '0;
    logic [7:0]  in_tid = '0;
    logic [2:0]  lp_ready = '0;
    logic        pt_ready = 1'b0;

    logic        v0, v1, r0, r1, pv0, pv1, ps0, ps1, pe0, pe1, d0, d1;
    logic [2:0]  lv0, lv1, ls0, ls1, le0, le1;
    logic [95:0] ld0, ld1;
    logic [31:0] pd0, pd1;

    assign v0 = drv_valid && !sel;
    assign v1 = drv_valid && sel;

    rx_pkt_router u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_ready(r0),
        .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data), .in_err(in_err),
        .in_tt(in_tt), .in_ftype(in_ftype), .in_dest(in_dest), .in_tid(in_tid),
        .lp_valid(lv0), .lp_ready(lp_ready), .lp_sop(ls0), .lp_eop(le0), .lp_data(ld0),
        .pt_valid(pv0), .pt_ready(pt_ready), .pt_sop(ps0), .pt_eop(pe0), .pt_data(pd0),
        .drop_pulse(d0)
    );

    rx_pkt_router #(.DEVID16_EN(1'b0), .DESTID_CHECK(1'b0), .PASSTHRU_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(r1),
        .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data), .in_err(in_err),
        .in_tt(in_tt), .in_ftype(in_ftype), .in_dest(in_dest), .in_tid(in_tid),
        .lp_valid(lv1), .lp_ready(lp_ready), .lp_sop(ls1), .lp_eop(le1), .lp_data(ld1),
        .pt_valid(pv1), .pt_ready(pt_ready), .pt_sop(ps1), .pt_eop(pe1), .pt_data(pd1),
        .drop_pulse(d1)
    );

    // Observed view of the instance under test
    logic [3:0]  o_vec;
    logic        o_rdy, o_drop;
    logic [95:0] o_ld;
    logic [31:0] o_pd;
    logic [2:0]  o_ls, o_le;
    logic        o_ps, o_pe;
    assign o_vec  = sel ? {pv1, lv1} : {pv0, lv0};
    assign o_rdy  = sel ? r1 : r0;
    assign o_drop = sel ? d1 : d0;
    assign o_ld   = sel ? ld1 : ld0;
    assign o_pd   = sel ? pd1 : pd0;
    assign o_ls   = sel ? ls1 : ls0;
    assign o_le   = sel ? le1 : le0;
    assign o_ps   = sel ? ps1 : ps0;
    assign o_pe   = sel ? pe1 : pe0;

    // Configuration tables written from the requirements
    logic [15:0] bmask [3] = '{16'h0024, 16'h0060, 16'h0500};
    logic [7:0]  blo   [3] = '{8'd0, 8'd32, 8'd48};
    logic [7:0]  bhi   [3] = '{8'd31, 8'd63, 8'd95};

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // code: 0..2 port, 3 pass-through, 4 drop with pulse, 5 silent drop
    task automatic model(input bit cfg, input bit err, input logic [1:0] tt,
                         input logic [3:0] ft, input logic [15:0] dst,
                         input logic [7:0] tid, output int code, output string tag);
        bit d16 = !cfg;
        bit dchk = !cfg;
        bit pt = !cfg;
        int hit = -1;
        if (err) begin code = 5; tag = "R1"; return; end
        if (tt != (d16 ? 2'd1 : 2'd0)) begin
            if (!d16 && tt == 2'd1) begin code = 4; tag = "R3"; return; end
            code = pt ? 3 : 4;
            tag = !pt ? "R8" : (tt >= 2'd2 ? "R12" : "R2");
            return;
        end
        if (dchk && dst != 16'h1234) begin code = 4; tag = "R4"; return; end
        if (!d16 && !dchk) tag = "R4";
        for (int i = 2; i >= 0; i--) begin
            if (ft == 4'd13) begin
                if (tid >= blo[i] && tid <= bhi[i]) hit = i;
            end else if (bmask[i][ft]) hit = i;
        end
        if (hit >= 0) begin
            code = hit;
            tag = (ft == 4'd13) ? "R7" : "R5";
        end else begin
            code = pt ? 3 : 4;
            tag = !pt ? "R8" : (ft == 4'd13 ? "R7" : "R6");
        end
    endtask

    task automatic send(input bit err, input logic [1:0] tt, input logic [3:0] ft,
                        input logic [15:0] dst, input logic [7:0] tid, input int len);
        int code;
        string tag;
        bit acc;
        logic [3:0] ev;
        model(sel, err, tt, ft, dst, tid, code, tag);
        ev = (code < 3) ? 4'(1 << code) : (code == 3 ? 4'b1000 : 4'b0000);
        for (int b = 0; b < len; b++) begin
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                drv_valid = 1'b1;
                in_sop = (b == 0);
                in_eop = (b == len - 1);
                in_data = $urandom;
                if (b == 0) begin
                    in_err = err; in_tt = tt; in_ftype = ft; in_dest = dst; in_tid = tid;
                end else begin
                    // scrambled header fields on later beats must not matter
                    in_err = 1'(~err); in_tt = 2'($urandom); in_ftype = 4'($urandom);
                    in_dest = 16'($urandom); in_tid = 8'($urandom);
                end
                lp_ready = {($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0};
                pt_ready = ($urandom % 4) != 0;
                #1;
                chk(o_vec == ev, (b == 0) ? tag : "R9", "target", o_vec, ev);
                begin
                    logic er;
                    er = (code < 3) ? lp_ready[code] : (code == 3 ? pt_ready : 1'b1);
                    chk(o_rdy == er, "R10", "in_ready", o_rdy, er);
                    chk(o_drop == (in_eop && code == 4), "R11", "drop_pulse",
                        o_drop, in_eop && code == 4);
                    if (code < 3) begin
                        chk(o_ld[code*32 +: 32] == in_data && o_ls[code] == in_sop &&
                            o_le[code] == in_eop, "R9", "port beat",
                            o_ld[code*32 +: 32], in_data);
                    end else if (code == 3) begin
                        chk(o_pd == in_data && o_ps == in_sop && o_pe == in_eop,
                            "R9", "pass beat", o_pd, in_data);
                    end
                    acc = er;
                end
                @(posedge clk);
            end
        end
        @(negedge clk);
        drv_valid = 1'b0;
        #1;
        chk(o_vec == 4'b0 && !o_drop, "R10", "idle", {o_vec, o_drop}, 0);
    endtask

    task automatic rand_pkt();
        logic [1:0] tt;
        logic [3:0] ft;
        logic [15:0] dst;
        int r = $urandom % 8;
        tt = (r < 3) ? 2'd1 : (r < 6) ? 2'd0 : 2'(2 + ($urandom % 2));
        ft = (($urandom % 3) == 0) ? 4'd13 : 4'($urandom);
        dst = (($urandom % 3) != 0) ? (sel ? {8'($urandom), 8'h34} : 16'h1234) : 16'($urandom);
        send(($urandom % 10) == 0, tt, ft, dst, 8'($urandom % 128), 1 + $urandom % 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        #1;
        chk(o_vec == 4'b0 && !o_drop, "R10", "reset state", {o_vec, o_drop}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // instance u0: 16-bit IDs, destination check, pass-through present
        sel = 1'b0;
        send(1'b1, 2'd1, 4'd2, 16'h1234, 8'd0, 3);   // R1
        send(1'b0, 2'd0, 4'd2, 16'h0034, 8'd0, 2);   // R2
        send(1'b0, 2'd1, 4'd2, 16'h1235, 8'd0, 2);   // R4 mismatch
        send(1'b0, 2'd1, 4'd5, 16'h1234, 8'd0, 2);   // R5 overlap -> port 0
        send(1'b0, 2'd1, 4'd6, 16'h1234, 8'd0, 1);   // R5 port 1
        send(1'b0, 2'd1, 4'd10, 16'h1234, 8'd0, 3);  // R5 port 2
        send(1'b0, 2'd1, 4'd11, 16'h1234, 8'd0, 2);  // R6
        send(1'b0, 2'd1, 4'd13, 16'h1234, 8'd31, 1); // R7 edges
        send(1'b0, 2'd1, 4'd13, 16'h1234, 8'd32, 1);
        send(1'b0, 2'd1, 4'd13, 16'h1234, 8'd48, 2); // overlap -> port 1
        send(1'b0, 2'd1, 4'd13, 16'h1234, 8'd63, 1);
        send(1'b0, 2'd1, 4'd13, 16'h1234, 8'd64, 1);
        send(1'b0, 2'd1, 4'd13, 16'h1234, 8'd95, 1);
        send(1'b0, 2'd1, 4'd13, 16'h1234, 8'd96, 2);
        send(1'b0, 2'd3, 4'd2, 16'h1234, 8'd0, 2);   // R12
        for (int n = 0; n < 400; n++) rand_pkt();

        // instance u1: 8-bit IDs, no destination check, no pass-through
        sel = 1'b1;
        send(1'b0, 2'd1, 4'd2, 16'h0034, 8'd0, 2);   // R3
        send(1'b0, 2'd0, 4'd11, 16'h0034, 8'd0, 3);  // R8
        send(1'b0, 2'd2, 4'd2, 16'h0034, 8'd0, 1);   // R12 / R8
        send(1'b0, 2'd0, 4'd6, 16'hBEEF, 8'd0, 2);   // check off
        send(1'b0, 2'd0, 4'd13, 16'h0034, 8'd200, 1);
        send(1'b1, 2'd1, 4'd2, 16'h0034, 8'd0, 2);   // R1
        for (int n = 0; n < 400; n++) rand_pkt();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule